// File: doc/BRIEF.md
# Reset Cause Recorder and Start Address Selector

This block collects the reset requests of a small microcontroller, merges them into one synchronous system reset of guaranteed length, and keeps a sticky record of which requests have occurred. Software reads the record as an 8-bit register and clears individual entries by writing zeros. A power-on event restarts the record with a fixed pattern. Every other event adds its own entry to whatever is already there.

When the system reset is released, the block also chooses where the processor begins fetching. It picks a boot page whose high byte is a programmable vector byte and whose low byte is zero. It picks this page if the most recent reset included a serial-line break request, if the non-volatile boot-status bit is high, or if the ISP strap was high at the latest power-on. In every other case it picks address zero. The chosen address is held until the next reset ends.

Top module: `rst_cause_top`

## Requirements
- R1: Flag positions are fixed: bit 0 external pin, bit 1 power-on, bit 2 brownout, bit 3 watchdog, bit 4 software, bit 5 serial break (req_i uses the same positions); bits 7:6 always read 0.
- R2: A power-on request makes the flags exactly 8'h06 on the next cycle (power-on and brownout set, all others cleared), even if other requests arrive at the same time.
- R3: A request other than power-on sets its own flag on the next cycle and leaves every other flag unchanged.
- R4: Several simultaneous non-power-on requests set all of their flags together.
- R5: A write clears each flag whose wr_data_i bit is 0 and leaves unchanged each flag whose bit is 1.
- R6: When a write clears a bit in the same cycle that a request sets it, the bit ends up set.
- R7: sys_rst_o goes high on the cycle after any request and stays high for HOLD_CYC cycles (default 2) after the last request, then goes low.
- R8: When sys_rst_o falls, vector_o becomes {boot_vec_i, 8'h00} if the latest request set included serial break, boot_stat_i is 1, or isp_force_i was 1 at the latest power-on request; otherwise vector_o becomes 16'h0000.
- R9: vector_o does not change while sys_rst_o is low, whatever boot_vec_i, boot_stat_i or isp_force_i do.
- R10: While rst_ni is low, the flags, sys_rst_o and vector_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| req_i | input | 6 | Reset request pulses, one per source |
| boot_stat_i | input | 1 | Non-volatile boot-status bit |
| isp_force_i | input | 1 | ISP strap, sampled at power-on request |
| boot_vec_i | input | 8 | Boot page high byte |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | 8 | Write data; 0 bits clear flags |
| flags_o | output | 8 | Flag register read value |
| sys_rst_o | output | 1 | Combined synchronous system reset |
| vector_o | output | 16 | First fetch address |

## Verification
The assertions assume that the request lines, the write strobe and the boot inputs are synchronous to clk_i and change only between edges. They also assume that no request stays high for so long that the check on the stretch window cannot tell a new request from a held one. The bench drives every input on the falling edge. It makes each request a single-cycle pulse and lets the stretch run out before it looks at the vector. It changes boot_vec_i and boot_stat_i only while sys_rst_o is low, apart from the cases where the latched choice is being tested.

// File: rtl/rst_trk_pkg.sv
package rst_trk_pkg;
  localparam int NUM_SRC = 6;
  localparam int FLAG_W  = 8;
  localparam int SRC_EXT = 0;
  localparam int SRC_POR = 1;
  localparam int SRC_BOD = 2;
  localparam int SRC_WDT = 3;
  localparam int SRC_SW  = 4;
  localparam int SRC_BRK = 5;

  localparam logic [NUM_SRC-1:0] POR_SET =
    NUM_SRC'((1 << SRC_POR) | (1 << SRC_BOD));
endpackage

// File: rtl/rst_flag_reg.sv
module rst_flag_reg
  import rst_trk_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int OUT_W = FLAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             wr_en_i,
  input  logic [OUT_W-1:0] wr_data_i,
  output logic [OUT_W-1:0] flags_o
);
  logic [N_SRC-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic keep;
    assign keep = flag_q[i] & ~(wr_en_i & ~wr_data_i[i]);
    // power-on overrides everything; otherwise set wins over clear
    assign flag_d[i] = req_i[SRC_POR] ? POR_SET[i] : (req_i[i] | keep);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_out
    if (i < N_SRC) begin : g_live
      assign flags_o[i] = flag_q[i];
    end else begin : g_zero
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_any_i,
  output logic rst_o,
  output logic release_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (req_any_i)         cnt_q <= CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o     = (cnt_q != '0);
  assign release_o = (cnt_q == CNT_W'(1)) && !req_any_i;
endmodule

// File: rtl/boot_vec_sel.sv
module boot_vec_sel #(
  parameter int BV_W  = 8,
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_any_i,
  input  logic             brk_req_i,
  input  logic             por_req_i,
  input  logic             isp_force_i,
  input  logic             boot_stat_i,
  input  logic [BV_W-1:0]  boot_vec_i,
  input  logic             release_i,
  output logic [VEC_W-1:0] vector_o
);
  localparam int LO_W = VEC_W - BV_W;
  logic last_brk_q, isp_q, use_boot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_brk_q <= 1'b0;
      isp_q      <= 1'b0;
    end else begin
      if (req_any_i) last_brk_q <= brk_req_i;
      if (por_req_i) isp_q      <= isp_force_i;
    end
  end

  assign use_boot = last_brk_q | isp_q | boot_stat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vector_o <= '0;
    else if (release_i) vector_o <= use_boot ? {boot_vec_i, {LO_W{1'b0}}} : '0;
  end
endmodule

// File: rtl/rst_cause_top.sv
module rst_cause_top
  import rst_trk_pkg::*;
#(
  parameter int HOLD_CYC = 2,
  parameter int BV_W     = 8,
  parameter int VEC_W    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               boot_stat_i,
  input  logic               isp_force_i,
  input  logic [BV_W-1:0]    boot_vec_i,
  input  logic               wr_en_i,
  input  logic [FLAG_W-1:0]  wr_data_i,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               sys_rst_o,
  output logic [VEC_W-1:0]   vector_o
);
  logic req_any, rel;

  assign req_any = |req_i;

  rst_flag_reg #(.N_SRC(NUM_SRC), .OUT_W(FLAG_W)) u_flags (
    .clk_i, .rst_ni, .req_i, .wr_en_i, .wr_data_i, .flags_o
  );

  rst_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk_i, .rst_ni, .req_any_i(req_any), .rst_o(sys_rst_o), .release_o(rel)
  );

  boot_vec_sel #(.BV_W(BV_W), .VEC_W(VEC_W)) u_vec (
    .clk_i, .rst_ni,
    .req_any_i  (req_any),
    .brk_req_i  (req_i[SRC_BRK]),
    .por_req_i  (req_i[SRC_POR]),
    .isp_force_i,
    .boot_stat_i,
    .boot_vec_i,
    .release_i  (rel),
    .vector_o
  );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk
  import rst_trk_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_i,
  input logic               wr_en_i,
  input logic [FLAG_W-1:0]  flags_o,
  input logic               sys_rst_o,
  input logic [15:0]        vector_o
);
  logic [NUM_SRC-1:0] nonpor_req;
  assign nonpor_req = req_i & ~NUM_SRC'(1 << SRC_POR);

  // R1
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLAG_W-1:NUM_SRC] == '0);

  // R2
  por_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[SRC_POR] |=> flags_o == FLAG_W'(8'h06));

  // R3
  src_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i[SRC_POR] && nonpor_req != '0) |=>
      ((flags_o[NUM_SRC-1:0] & $past(nonpor_req)) == $past(nonpor_req)));

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && !wr_en_i) |=> $stable(flags_o));

  // R7
  rst_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |=> sys_rst_o);

  // R7
  rst_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |=> sys_rst_o);

  // R8
  vec_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o[7:0] == 8'h00);

  // R9
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && !$past(sys_rst_o)) |-> $stable(vector_o));
endmodule

bind rst_cause_top rst_cause_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_en_i(wr_en_i),
  .flags_o(flags_o), .sys_rst_o(sys_rst_o), .vector_o(vector_o)
);

// File: tb/sim_rst_cause_top.sv
module sim_rst_cause_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  req = '0;
  logic        boot_stat = 1'b0, isp_force = 1'b0, wr_en = 1'b0;
  logic [7:0]  boot_vec = 8'h3C, wr_data = '0;
  logic [7:0]  flags;
  logic        sys_rst;
  logic [15:0] vector;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rst_cause_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .boot_stat_i(boot_stat),
    .isp_force_i(isp_force), .boot_vec_i(boot_vec), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .flags_o(flags), .sys_rst_o(sys_rst), .vector_o(vector)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk) req = v;
    @(negedge clk) req = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 flags", 32'(flags), 32'h00);
    chk("R10 sys_rst", 32'(sys_rst), 32'h0);
    chk("R10 vector", 32'(vector), 32'h0000);
  endtask

  task automatic t_por();
    isp_force = 1'b1; boot_vec = 8'h3C;
    pulse(6'b000010);
    chk("R2 flags", 32'(flags), 32'h06);
    chk("R8 isp vector", 32'(vector), 32'h3C00);
    isp_force = 1'b0;
    pulse(6'b000010);
    chk("R2 flags again", 32'(flags), 32'h06);
    chk("R8 plain vector", 32'(vector), 32'h0000);
  endtask

  task automatic t_sticky();
    pulse(6'b001000);
    chk("R3 wdt", 32'(flags), 32'h0E);
    wr(8'hFD);
    chk("R5 clear bit1", 32'(flags), 32'h0C);
    wr(8'hFF);
    chk("R5 ones keep", 32'(flags), 32'h0C);
    chk("R1 upper zero", 32'(flags[7:6]), 32'h0);
  endtask

  task automatic t_vectors();
    pulse(6'b100000);
    chk("R3 brk", 32'(flags), 32'h2C);
    chk("R8 brk vector", 32'(vector), 32'h3C00);
    pulse(6'b000001);
    chk("R3 ext", 32'(flags), 32'h2D);
    chk("R8 ext vector", 32'(vector), 32'h0000);
    boot_stat = 1'b1;
    pulse(6'b010000);
    chk("R3 sw", 32'(flags), 32'h3D);
    chk("R8 stat vector", 32'(vector), 32'h3C00);
    boot_vec = 8'h77; boot_stat = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 hold", 32'(vector), 32'h3C00);
  endtask

  task automatic t_collide();
    wr(8'h00);
    chk("R5 clear all", 32'(flags), 32'h00);
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h00; req = 6'b010000; end
    @(negedge clk) begin wr_en = 1'b0; req = '0; end
    chk("R6 set wins", 32'(flags), 32'h10);
    repeat (4) @(negedge clk);
    wr(8'h00);
    pulse(6'b001001);
    chk("R4 multi", 32'(flags), 32'h09);
  endtask

  task automatic t_stretch();
    int hi = 0;
    @(negedge clk) req = 6'b010000;
    @(negedge clk) req = '0;
    for (int i = 0; i < 6; i++) begin
      if (sys_rst) hi++;
      @(negedge clk);
    end
    chk("R7 hold cycles", 32'(hi), 32'd2);
    chk("R7 released", 32'(sys_rst), 32'h0);
    pulse(6'b111111);
    chk("R2 por priority", 32'(flags), 32'h06);
    chk("R8 brk with por", 32'(vector), 32'h7700);
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_por();
    t_sticky();
    t_vectors();
    t_collide();
    t_stretch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule